// File: doc/BRIEF.md
# Pixel-Rate Digital Offset and Gain Corrector

This block sits right after the image converter. Each incoming pixel word first has a digital offset removed. The result is then scaled by a digital gain. The gain and offset values for each pixel arrive together with the pixel, on one group of correction pins. A static split field decides how those pins are divided between the gain word and the offset word. The low gain pins can be moved to the top of the offset word, which trades gain resolution for offset range.

A second static field selects the full-scale range of the multiplier: 2x, 4x or 8x. The gain word is an unsigned fraction of that range. Either stage is bypassed when its whole field is clear.

A negative difference clamps to zero. A product above full scale clamps to the all-ones code. The datapath has a fixed two-cycle latency, and a valid flag travels with each word.

Top module: `pix_corr`

## Requirements
- R1: While reset is low, and on the first edge after it rises, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` goes high exactly two clock edges after the edge that samples `in_valid` high, and it carries the result for that pixel. While `out_valid` is low, `out_data` holds its last value.
- R3: With `split_sel` = 3'b000 the subtracter is bypassed: the difference equals `in_data`, and all 12 `gain_pins` form the gain word.
- R4: With only `split_sel[2]` set, the offset word is the 8 `offset_pins`, and the gain word is all 12 `gain_pins`.
- R5: With only `split_sel[1]` set, the offset word is {`gain_pins[0]`, `offset_pins`} (9 bits), and the gain word is `gain_pins[11:1]` (11 bits).
- R6: With `split_sel[0]` set, the offset word is {`gain_pins[1:0]`, `offset_pins`} (10 bits), and the gain word is `gain_pins[11:2]` (10 bits).
- R7: When the offset word is at least `in_data`, the difference is 0.
- R8: `scale_sel[0]`, `scale_sel[1]` and `scale_sel[2]` select a full scale of 2, 4 and 8. The output is floor(diff × G × full scale / 2^W), where G is the gain word and W is its width. A gain word of zero gives 0.
- R9: A product above 4095 is output as 4095.
- R10: With `scale_sel` = 3'b000 the multiplier is bypassed and the output equals the difference.
- R11: When several bits of one field are set, the lowest-numbered set bit decides the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel word present this cycle |
| in_data | input | 12 | Converter output word |
| gain_pins | input | 12 | Per-pixel correction pins, gain group |
| offset_pins | input | 8 | Per-pixel correction pins, offset group |
| split_sel | input | 3 | Gain/offset pin split and subtracter enable |
| scale_sel | input | 3 | Multiplier full-scale range and multiplier enable |
| out_valid | output | 1 | Corrected word present |
| out_data | output | 12 | Corrected pixel word |

## Verification
Because of the pipeline, one pixel can be in the multiplier stage while the next is in the subtracter stage. In that same cycle, one pixel can saturate or clamp while its neighbour is being split under a different mode. The bench provokes this by streaming the whole vector table back to back, with `in_valid` high on every cycle and split and scale changing on every word. Each output is judged against its own pixel's expected value two edges later. A lone valid word between idle cycles then confirms the latency and that the output holds.

// File: rtl/pix_corr_pkg.sv
package pix_corr_pkg;

    localparam int SPLIT_W = 3;
    localparam int SCALE_W = 3;

    // How the correction pins are divided between the gain and offset words
    typedef enum logic [1:0] {
        SPLIT_BYPASS   = 2'd0,   // no subtraction, full-width gain
        SPLIT_GAIN_MAX = 2'd1,   // full gain, offset pins only
        SPLIT_ONE_MOVE = 2'd2,   // one gain LSB moved to offset MSB
        SPLIT_TWO_MOVE = 2'd3    // two gain LSBs moved to offset MSBs
    } split_mode_e;

endpackage

// File: rtl/pix_corr_cfg.sv
module pix_corr_cfg
    import pix_corr_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int OPIN_W = 8
) (
    input  logic [SPLIT_W-1:0] split_sel,
    input  logic [SCALE_W-1:0] scale_sel,
    input  logic [DATA_W-1:0]  gain_pins,
    input  logic [OPIN_W-1:0]  offset_pins,
    output logic               sub_en,
    output logic [DATA_W-1:0]  off_word,
    output logic [DATA_W-1:0]  gain_norm,
    output logic               mul_en,
    output logic [1:0]         scale_k
);

    localparam int PAD_W = DATA_W - OPIN_W - 2;

    split_mode_e mode;

    // lowest-numbered set bit decides the split mode
    always_comb begin
        if (split_sel[0])      mode = SPLIT_TWO_MOVE;
        else if (split_sel[1]) mode = SPLIT_ONE_MOVE;
        else if (split_sel[2]) mode = SPLIT_GAIN_MAX;
        else                   mode = SPLIT_BYPASS;
    end

    // gain normalised to DATA_W bits, so that every mode shares one fraction scale
    always_comb begin
        sub_en = (mode != SPLIT_BYPASS);
        unique case (mode)
            SPLIT_TWO_MOVE: begin
                off_word  = {{PAD_W{1'b0}}, gain_pins[1:0], offset_pins};
                gain_norm = {gain_pins[DATA_W-1:2], 2'b00};
            end
            SPLIT_ONE_MOVE: begin
                off_word  = {{PAD_W{1'b0}}, 1'b0, gain_pins[0], offset_pins};
                gain_norm = {gain_pins[DATA_W-1:1], 1'b0};
            end
            default: begin
                off_word  = {{PAD_W{1'b0}}, 2'b00, offset_pins};
                gain_norm = gain_pins;
            end
        endcase
    end

    // scale_k is log2 of the full-scale multiplier
    always_comb begin
        mul_en  = 1'b1;
        if (scale_sel[0])      scale_k = 2'd1;
        else if (scale_sel[1]) scale_k = 2'd2;
        else if (scale_sel[2]) scale_k = 2'd3;
        else begin
            scale_k = 2'd0;
            mul_en  = 1'b0;
        end
    end

endmodule

// File: rtl/pix_corr_sub.sv
module pix_corr_sub #(
    parameter int DATA_W = 12
) (
    input  logic              sub_en,
    input  logic [DATA_W-1:0] pix,
    input  logic [DATA_W-1:0] off_word,
    output logic [DATA_W-1:0] diff
);

    always_comb begin
        if (!sub_en)              diff = pix;
        else if (off_word >= pix) diff = '0;
        else                      diff = pix - off_word;
    end

endmodule

// File: rtl/pix_corr_mul.sv
module pix_corr_mul #(
    parameter int DATA_W = 12
) (
    input  logic              mul_en,
    input  logic [1:0]        scale_k,
    input  logic [DATA_W-1:0] diff,
    input  logic [DATA_W-1:0] gain_norm,
    output logic [DATA_W-1:0] result
);

    localparam int PROD_W = 2 * DATA_W;
    localparam int SH_W   = $clog2(PROD_W + 1);

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;
    logic [SH_W-1:0]   sh;

    always_comb begin
        prod   = PROD_W'(diff) * PROD_W'(gain_norm);
        sh     = SH_W'(DATA_W) - SH_W'(scale_k);
        scaled = prod >> sh;
        if (!mul_en)
            result = diff;
        else if (|scaled[PROD_W-1:DATA_W])
            result = '1;
        else
            result = scaled[DATA_W-1:0];
    end

endmodule

// File: rtl/pix_corr.sv
module pix_corr
    import pix_corr_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int OPIN_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [DATA_W-1:0]  gain_pins,
    input  logic [OPIN_W-1:0]  offset_pins,
    input  logic [SPLIT_W-1:0] split_sel,
    input  logic [SCALE_W-1:0] scale_sel,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data
);

    typedef struct packed {
        logic              s1_valid;
        logic [DATA_W-1:0] s1_diff;
        logic [DATA_W-1:0] s1_gain;
        logic              s1_mul_en;
        logic [1:0]        s1_k;
        logic              s2_valid;
        logic [DATA_W-1:0] s2_data;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic              sub_en, mul_en;
    logic [DATA_W-1:0] off_word, gain_norm, diff, mul_res;
    logic [1:0]        scale_k;

    pix_corr_cfg #(.DATA_W(DATA_W), .OPIN_W(OPIN_W)) u_cfg (
        .split_sel  (split_sel),
        .scale_sel  (scale_sel),
        .gain_pins  (gain_pins),
        .offset_pins(offset_pins),
        .sub_en     (sub_en),
        .off_word   (off_word),
        .gain_norm  (gain_norm),
        .mul_en     (mul_en),
        .scale_k    (scale_k)
    );

    pix_corr_sub #(.DATA_W(DATA_W)) u_sub (
        .sub_en  (sub_en),
        .pix     (in_data),
        .off_word(off_word),
        .diff    (diff)
    );

    pix_corr_mul #(.DATA_W(DATA_W)) u_mul (
        .mul_en   (pipe_q.s1_mul_en),
        .scale_k  (pipe_q.s1_k),
        .diff     (pipe_q.s1_diff),
        .gain_norm(pipe_q.s1_gain),
        .result   (mul_res)
    );

    always_comb begin
        pipe_d          = pipe_q;
        pipe_d.s1_valid = in_valid;
        if (in_valid) begin
            pipe_d.s1_diff   = diff;
            pipe_d.s1_gain   = gain_norm;
            pipe_d.s1_mul_en = mul_en;
            pipe_d.s1_k      = scale_k;
        end
        pipe_d.s2_valid = pipe_q.s1_valid;
        if (pipe_q.s1_valid)
            pipe_d.s2_data = mul_res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.s2_valid;
    assign out_data  = pipe_q.s2_data;

endmodule

// File: rtl/pix_corr_chk.sv
module pix_corr_chk #(
    parameter int DATA_W = 12,
    parameter int OPIN_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [DATA_W-1:0] gain_pins,
    input logic [OPIN_W-1:0] offset_pins,
    input logic [2:0]        split_sel,
    input logic [2:0]        scale_sel,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    logic [1:0]        age_q;
    logic [DATA_W-1:0] off_ext;
    logic              warm, under, zero_gain, both_bypass;

    always_ff @(posedge clk) begin
        if (!rst_n)          age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    assign warm        = (age_q >= 2'd2);
    assign off_ext     = {{(DATA_W-OPIN_W){1'b0}}, offset_pins};
    assign under       = in_valid && (|split_sel) && (off_ext >= in_data);
    assign zero_gain   = in_valid && (|scale_sel) && (gain_pins == '0);
    assign both_bypass = in_valid && (split_sel == '0) && (scale_sel == '0);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && out_data == '0));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 2)));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !out_valid) |-> $stable(out_data));

    // R7
    clamp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(under, 2)) |-> (out_data == '0));

    // R8
    zero_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(zero_gain, 2)) |-> (out_data == '0));

    // R10
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(both_bypass, 2)) |-> (out_data == $past(in_data, 2)));

endmodule

bind pix_corr pix_corr_chk #(.DATA_W(DATA_W), .OPIN_W(OPIN_W)) u_chk (.*);

// File: tb/pix_corr_tb.sv
module pix_corr_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_data = '0;
    logic [11:0] gain_pins = '0;
    logic [7:0]  offset_pins = '0;
    logic [2:0]  split_sel = '0;
    logic [2:0]  scale_sel = '0;
    logic        out_valid;
    logic [11:0] out_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pix_corr u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .gain_pins(gain_pins), .offset_pins(offset_pins),
        .split_sel(split_sel), .scale_sel(scale_sel),
        .out_valid(out_valid), .out_data(out_data)
    );

    typedef struct packed {
        logic [11:0] x;
        logic [11:0] g;
        logic [7:0]  o;
        logic [2:0]  sp;
        logic [2:0]  sc;
        logic [11:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{12'h5A5, 12'hFFF, 8'hFF, 3'b000, 3'b000, 12'h5A5}, // R3 R10 both bypassed
        '{12'd1000, 12'h123, 8'd200, 3'b100, 3'b000, 12'd800}, // R4
        '{12'd1000, 12'h001, 8'h10, 3'b010, 3'b000, 12'd728}, // R5 offset 272
        '{12'd2000, 12'h003, 8'h00, 3'b001, 3'b000, 12'd1232}, // R6 offset 768
        '{12'd50, 12'h000, 8'd100, 3'b100, 3'b000, 12'd0}, // R7
        '{12'd1000, 12'h800, 8'h00, 3'b000, 3'b001, 12'd1000}, // R8 2x
        '{12'd1000, 12'h600, 8'h00, 3'b000, 3'b010, 12'd1500}, // R8 4x
        '{12'd1000, 12'h300, 8'h00, 3'b000, 3'b100, 12'd1500}, // R8 8x
        '{12'd4000, 12'hFFF, 8'h00, 3'b000, 3'b100, 12'd4095}, // R9
        '{12'd2000, 12'h801, 8'h00, 3'b001, 3'b010, 12'd3488}, // R6 R8
        '{12'd1256, 12'h7FF, 8'h00, 3'b010, 3'b001, 12'd999}, // R5 R8 just under 2x
        '{12'd2000, 12'h003, 8'h00, 3'b111, 3'b000, 12'd1232}, // R11 split
        '{12'd1000, 12'h600, 8'h00, 3'b000, 3'b110, 12'd1500}, // R11 scale
        '{12'd2000, 12'h002, 8'h00, 3'b011, 3'b000, 12'd1488}  // R11 split
    };

    string VTAG [NV] = '{"R3/R10", "R4", "R5", "R6", "R7", "R8", "R8", "R8",
                         "R9", "R6/R8", "R5/R8", "R11", "R11", "R11"};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic vld);
        in_valid    = vld;
        in_data     = v.x;
        gain_pins   = v.g;
        offset_pins = v.o;
        split_sel   = v.sp;
        scale_sel   = v.sc;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 valid in reset", out_valid, 0);
        check("R1 data in reset", out_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", out_valid, 0);
        check("R1 data after reset", out_data, 0);

        // stream the table back to back
        for (int c = 0; c < NV + 2; c++) begin
            @(negedge clk);
            if (c >= 2) begin
                check({VTAG[c-2], " valid"}, out_valid, 1);
                check(VTAG[c-2], out_data, VEC[c-2].exp);
            end
            if (c < NV) drive(VEC[c], 1'b1);
            else        drive(VEC[0], 1'b0);
        end

        // R2 idle: output holds last value
        repeat (3) @(negedge clk);
        check("R2 idle valid", out_valid, 0);
        check("R2 idle hold", out_data, VEC[NV-1].exp);

        // R2 lone word latency
        drive(VEC[6], 1'b1);
        @(negedge clk);
        drive(VEC[0], 1'b0);
        check("R2 one edge", out_valid, 0);
        @(negedge clk);
        check("R2 two edges", out_valid, 1);
        check("R2 lone data", out_data, VEC[6].exp);
        @(negedge clk);
        check("R2 pulse ends", out_valid, 0);
        check("R2 hold after pulse", out_data, VEC[6].exp);

        // R1 reset mid-stream clears outputs
        drive(VEC[8], 1'b1);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset valid", out_valid, 0);
        check("R1 mid reset data", out_data, 0);
        drive(VEC[0], 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 release valid", out_valid, 0);

        finish_run();
    end

endmodule